// File: doc/BRIEF.md
# Edge-Latched Bridge Interrupt Controller

This block sits between a group of peripheral event lines and a parent interrupt controller. Each source is treated as an edge event: a low-to-high transition on a source line sets a sticky pending bit in a cause register. A separate enable register selects which pending bits may reach the single registered interrupt output. That output stays high while any enabled pending bit remains set.

Software services the output by reading the cause register and acknowledging events. It writes a word in which the bits to be acknowledged are zero and every other bit is one. Pending bits collect whether or not their source is enabled. Stale events therefore have to be acknowledged before a source is enabled. The number of implemented sources is a parameter. Register positions above that count do not exist and read as zero.

Top module: `edge_irq_bridge`

## Requirements
- R1: After a synchronous active-high reset, the cause register, the enable register and `irqOut` are all zero.
- R2: A source line that is low at one clock edge and high at the next sets its cause bit, and the bit is visible on readback after that edge. A source that stays high does not set its bit again after the bit has been acknowledged.
- R3: A cause bit is set by an edge even while its enable bit is zero, and a disabled pending bit does not raise `irqOut`.
- R4: The cause register is at byte offset 0x0. A write there clears every cause bit whose data bit is 0 and leaves every cause bit whose data bit is 1 unchanged.
- R5: If a source edge arrives in the same cycle as a write that would clear that source's cause bit, the bit ends up set.
- R6: The enable register is at byte offset 0x4. A write there loads it, it reads back what was written, and it holds its value while it is not written.
- R7: `irqOut` is 1 in the cycle after a cycle in which (cause AND enable) is nonzero, and 0 in the cycle after a cycle in which it is zero.
- R8: Cause and enable bit positions at or above `NUM_SRC` read as zero and cannot be set by writes.
- R9: Reads from any offset other than 0x0 and 0x4 return zero, and writes there change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcIn | input | NUM_SRC | Event source lines, sampled on the clock |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Byte offset of the register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the register at `regAddr`, combinational |
| irqOut | output | 1 | Registered interrupt request to the parent controller |

## Verification
The bench drives a single short pulse, a held high level, and a rising edge in the same cycle as an acknowledging write. These patterns separate edge detection from level detection, and they show whether an acknowledge can swallow a new event. Writes of all ones, all zeros and a single zero bit test the write-zero-to-clear rule. A write of all ones to the enable register, with fewer than 32 sources, exposes unimplemented positions. A long pseudo-random phase toggles many sources together and mixes writes to both registers and to unused offsets. A behavioural model checks the output and the readback on every cycle.

// File: rtl/edge_irq_bridge_pkg.sv
package edge_irq_bridge_pkg;
  localparam int DATA_W    = 32;
  localparam int CAUSE_OFS = 0;
  localparam int ENABLE_OFS = 4;

  typedef struct packed {
    logic wrCause;
    logic wrEnable;
    logic rdCause;
    logic rdEnable;
  } regStrobe_t;
endpackage

// File: rtl/edge_irq_bridge_ctrl.sv
module edge_irq_bridge_ctrl
  import edge_irq_bridge_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] causeAddr  = ADDR_W'(CAUSE_OFS);
  localparam logic [ADDR_W-1:0] enableAddr = ADDR_W'(ENABLE_OFS);

  logic hitCause;
  logic hitEnable;

  always_comb begin
    hitCause      = (regAddr == causeAddr);
    hitEnable     = (regAddr == enableAddr);
    strb.rdCause  = hitCause;
    strb.rdEnable = hitEnable;
    strb.wrCause  = regWrEn && hitCause;
    strb.wrEnable = regWrEn && hitEnable;
  end
endmodule

// File: rtl/edge_irq_bridge_dp.sv
module edge_irq_bridge_dp
  import edge_irq_bridge_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcIn,
  input  regStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [DATA_W-1:0]  causeQ,
  output logic [DATA_W-1:0]  enableQ,
  output logic [DATA_W-1:0]  edgeVec,
  output logic               irqOut
);
  logic irqQ;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < NUM_SRC) begin : g_live
      logic prevQ;
      logic ackThisBit;

      assign edgeVec[i]  = srcIn[i] && !prevQ;
      assign ackThisBit  = strb.wrCause && !wrData[i];

      always_ff @(posedge clk) begin
        if (rst) begin
          prevQ      <= 1'b0;
          causeQ[i]  <= 1'b0;
          enableQ[i] <= 1'b0;
        end else begin
          prevQ     <= srcIn[i];
          // a fresh edge wins over a same-cycle acknowledge
          causeQ[i] <= edgeVec[i] || (causeQ[i] && !ackThisBit);
          if (strb.wrEnable) enableQ[i] <= wrData[i];
        end
      end
    end else begin : g_absent
      assign edgeVec[i] = 1'b0;
      assign causeQ[i]  = 1'b0;
      assign enableQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irqQ <= 1'b0;
    else     irqQ <= |(causeQ & enableQ);
  end

  assign irqOut = irqQ;

  always_comb begin
    if (strb.rdCause)       rdData = causeQ;
    else if (strb.rdEnable) rdData = enableQ;
    else                    rdData = '0;
  end
endmodule

// File: rtl/edge_irq_bridge.sv
module edge_irq_bridge
  import edge_irq_bridge_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               irqOut
);
  regStrobe_t        strb;
  logic [DATA_W-1:0] causeQ;
  logic [DATA_W-1:0] enableQ;
  logic [DATA_W-1:0] edgeVec;

  edge_irq_bridge_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  edge_irq_bridge_dp #(.NUM_SRC(NUM_SRC)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .srcIn   (srcIn),
    .strb    (strb),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .causeQ  (causeQ),
    .enableQ (enableQ),
    .edgeVec (edgeVec),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/edge_irq_bridge_chk.sv
module edge_irq_bridge_chk
  import edge_irq_bridge_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input logic              clk,
  input logic              rst,
  input regStrobe_t        strb,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] causeQ,
  input logic [DATA_W-1:0] enableQ,
  input logic [DATA_W-1:0] edgeVec,
  input logic              irqOut
);
  localparam logic [DATA_W-1:0] implMask =
    (NUM_SRC >= DATA_W) ? '1 : ((DATA_W'(1) << NUM_SRC) - DATA_W'(1));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (causeQ == '0 && enableQ == '0 && !irqOut));

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((causeQ & $past(edgeVec)) == $past(edgeVec)));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !strb.wrCause |=> ((causeQ & $past(causeQ)) == $past(causeQ)));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.wrCause && edgeVec == '0) |=> ((causeQ & ~$past(regWrData)) == '0));

  assert_edge_beats_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (strb.wrCause && edgeVec != '0) |=> ((causeQ & $past(edgeVec)) != '0));

  assert_enable_load_R6: assert property (@(posedge clk) disable iff (rst)
    strb.wrEnable |=> (enableQ == ($past(regWrData) & implMask)));

  assert_enable_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strb.wrEnable |=> $stable(enableQ));

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (enableQ == '0) |=> !irqOut);
endmodule

bind edge_irq_bridge edge_irq_bridge_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .strb      (strb),
  .regWrData (regWrData),
  .causeQ    (causeQ),
  .enableQ   (enableQ),
  .edgeVec   (edgeVec),
  .irqOut    (irqOut)
);

// File: tb/edge_irq_bridge_tb_top.sv
`timescale 1ns/100ps
module edge_irq_bridge_tb_top;
  localparam int NSRC  = 24;
  localparam int AW    = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src = '0;
  logic            regWrEn = 1'b0;
  logic [AW-1:0]   regAddr = '0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     regRdData;
  logic            irqOut;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  edge_irq_bridge #(.NUM_SRC(NSRC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .srcIn(src), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  // behavioural reference model
  logic [31:0] mCause, mMask, mPrev, nC, nM;
  logic        mIrq;

  always @(posedge clk) begin
    if (rst) begin
      mCause <= '0; mMask <= '0; mPrev <= '0; mIrq <= 1'b0;
    end else begin
      mIrq <= (mCause & mMask) != 0;
      nC = '0; nM = '0;
      for (int i = 0; i < NSRC; i++) begin
        if (src[i] && !mPrev[i]) nC[i] = 1'b1;
        else if (mCause[i] && !(regWrEn && regAddr == 0 && !regWrData[i])) nC[i] = 1'b1;
        nM[i] = (regWrEn && regAddr == 4) ? regWrData[i] : mMask[i];
        mPrev[i] <= src[i];
      end
      mCause <= nC;
      mMask  <= nM;
    end
  end

  function automatic logic [31:0] modelRead(input logic [AW-1:0] a);
    if (a == 0) return mCause;
    if (a == 4) return mMask;
    return 32'h0;
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irqOut !== mIrq) begin
        fails++;
        $display("FAIL R7 cycle %0d: irqOut got %b exp %b", cyc, irqOut, mIrq);
      end
      checks++;
      if (regRdData !== modelRead(regAddr)) begin
        fails++;
        $display("FAIL R6 cycle %0d: read @%0h got %h exp %h", cyc, regAddr,
                 regRdData, modelRead(regAddr));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic writeReg(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); #0.5;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); #0.5;
    regWrEn = 1'b0;
  endtask

  task automatic expectRd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #0.5;
    checks++;
    if (regRdData !== exp) begin
      fails++;
      $display("FAIL %s: read @%0h got %h exp %h", tag, a, regRdData, exp);
    end
  endtask

  task automatic expectIrq(input logic exp, input string tag);
    checks++;
    if (irqOut !== exp) begin
      fails++;
      $display("FAIL %s: irqOut got %b exp %b", tag, irqOut, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  logic [31:0] rng = 32'h1234_5678;

  initial begin
    tick(5);
    rst = 1'b0;
    tick(1);
    expectRd(0, 32'h0, "R1");
    expectRd(4, 32'h0, "R1");
    expectIrq(1'b0, "R1");

    // short pulse on source 3 while disabled
    src[3] = 1'b1;
    tick(1);
    expectRd(0, 32'h8, "R2");
    src[3] = 1'b0;
    tick(1);
    expectIrq(1'b0, "R3");

    // held level on source 5
    src[5] = 1'b1;
    tick(3);
    expectRd(0, 32'h28, "R2");
    writeReg(0, ~32'h20);
    expectRd(0, 32'h8, "R4");
    tick(3);
    expectRd(0, 32'h8, "R2");

    // enable source 3
    writeReg(4, 32'h8);
    expectIrq(1'b0, "R7");
    tick(1);
    expectIrq(1'b1, "R7");
    expectRd(4, 32'h8, "R6");

    writeReg(0, 32'hFFFF_FFFF);
    expectRd(0, 32'h8, "R4");

    // edge on 7 together with a full acknowledge
    @(negedge clk); #0.5;
    src[7] = 1'b1; regWrEn = 1'b1; regAddr = 0; regWrData = 32'h0;
    @(negedge clk); #0.5;
    regWrEn = 1'b0;
    expectRd(0, 32'h80, "R5");
    tick(1);
    expectIrq(1'b0, "R7");

    writeReg(4, 32'hFFFF_FFFF);
    expectRd(4, 32'h00FF_FFFF, "R8");
    tick(1);
    expectIrq(1'b1, "R7");

    writeReg(8, 32'h0);
    expectRd(8, 32'h0, "R9");
    expectRd(4, 32'h00FF_FFFF, "R9");
    expectRd(0, 32'h80, "R9");

    writeReg(4, 32'h0);
    writeReg(0, 32'h0);
    tick(1);
    expectRd(0, 32'h0, "R4");
    expectRd(4, 32'h0, "R6");
    expectIrq(1'b0, "R7");

    // pseudo-random phase, checked every cycle by the model
    for (int k = 0; k < 400; k++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      src = rng[NSRC-1:0];
      regWrEn = (k % 5 == 0);
      regAddr = AW'(rng[28:27] * 4);
      regWrData = {rng[15:0], rng[31:16]};
      tick(1);
    end
    regWrEn = 1'b0;
    tick(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule